// File: doc/BRIEF.md
# Message Event Register File

This block keeps a small table of inter-task message slots for a hardware task scheduler. Each slot carries a busy flag, the identifier of the sending task, the identifier of the receiving task and a message payload. A sender posts a message with one command. The block places it in the lowest-numbered empty slot and marks the receiving task as having a pending synchronization event. The receiver later reads the slot by index and releases it with a take command.

A priority search runs combinationally over the busy flags at all times. It reports the index of the first empty slot and a flag that shows when the table has no room. The per-task event outputs come straight from the stored state. The scheduler therefore sees a post on the clock edge after it is accepted. Each event output stays high while any occupied slot still names that task as its receiver.

Top module: `msg_event_regfile`

## Requirements
- R1: While `rst_ni` is low and after it is released, every slot is empty, `free_idx_o` is 0, `full_o` is 0 and `sync_ev_o` is all zeros.
- R2: Whenever at least one slot is empty, `free_idx_o` gives the lowest index whose slot is empty.
- R3: `full_o` is 1 exactly when every slot is occupied.
- R4: When `post_i` is 1 and `full_o` is 0, `post_ok_o` is 1 in the same cycle. At the next edge the slot at `free_idx_o` takes the posted source, destination and payload and becomes occupied.
- R5: When `post_i` is 1 and `full_o` is 1, `post_rej_o` is 1 and `post_ok_o` is 0. No slot changes.
- R6: Bit t of `sync_ev_o` is 1 from the edge that stores a post with destination t. It stays 1 while any occupied slot has destination t, and it is 0 otherwise.
- R7: `take_ok_o` is 1 when `take_i` is 1, slot `take_slot_i` is occupied and its destination equals `take_task_i`. In that cycle `take_src_o` and `take_msg_o` show that slot's source and payload. The slot is empty after the next edge.
- R8: A take that names an empty slot, or a task other than the stored destination, gives `take_ok_o` = 0 and leaves every slot unchanged.
- R9: A post and a take in the same cycle are judged against the state before the edge. The post uses the empty slot found before the take. A post into a full table is rejected even if a take frees a slot in the same cycle. After the edge, `free_idx_o` and `full_o` reflect both actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_i | input | 1 | Post command |
| post_src_i | input | TASK_W | Sending task ID |
| post_dst_i | input | TASK_W | Receiving task ID |
| post_msg_i | input | MSG_W | Message payload |
| post_ok_o | output | 1 | Post accepted this cycle |
| post_rej_o | output | 1 | Post refused, table full |
| take_i | input | 1 | Take command |
| take_slot_i | input | IDX_W | Slot to read and release |
| take_task_i | input | TASK_W | Task issuing the take |
| take_ok_o | output | 1 | Take accepted this cycle |
| take_src_o | output | TASK_W | Source ID of the addressed slot |
| take_msg_o | output | MSG_W | Payload of the addressed slot |
| free_idx_o | output | IDX_W | Lowest empty slot index |
| full_o | output | 1 | All slots occupied |
| sync_ev_o | output | 2**TASK_W | Pending synchronization event per task |

## Verification
The bench posts messages until the table fills, then punches a hole below the top so the search must return a middle index. A search that scans from the top or keeps a stale pointer would report the wrong index. It then issues a post into a full table alongside a take. A design that lets the freed slot absorb that post would accept it. A second post plus take on a non-full table shows whether the post is steered into the slot being freed. Takes with a wrong task or an empty slot catch an ownership check that was missed. Two messages to the same task, released one at a time, show whether the event bit drops too early.

// File: rtl/msg_evrf_pkg.sv
package msg_evrf_pkg;
  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/msg_slot.sv
module msg_slot #(
  parameter int TASK_W = 3,
  parameter int MSG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [TASK_W-1:0] src_i,
  input  logic [TASK_W-1:0] dst_i,
  input  logic [MSG_W-1:0]  msg_i,
  output logic              busy_o,
  output logic [TASK_W-1:0] src_o,
  output logic [TASK_W-1:0] dst_o,
  output logic [MSG_W-1:0]  msg_o
);
  // busy flag kept as the top field of the entry
  typedef struct packed {
    logic              busy;
    logic [TASK_W-1:0] src;
    logic [TASK_W-1:0] dst;
    logic [MSG_W-1:0]  msg;
  } entry_t;

  entry_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      q <= '{busy: 1'b1, src: src_i, dst: dst_i, msg: msg_i};
    end else if (clr_i) begin
      q.busy <= 1'b0;
    end
  end

  assign busy_o = q.busy;
  assign src_o  = q.src;
  assign dst_o  = q.dst;
  assign msg_o  = q.msg;

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !busy_o); // R4
endmodule

// File: rtl/msg_free_search.sv
module msg_free_search #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     busy_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             full_o
);
  // scan high to low so the lowest empty index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign full_o = &busy_i;

  AST_IDX_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_o |-> !busy_i[idx_o]); // R2
endmodule

// File: rtl/msg_event_map.sv
module msg_event_map #(
  parameter int N         = 8,
  parameter int TASK_W    = 3,
  parameter int NUM_TASKS = 8
) (
  input  logic [N-1:0]      busy_i,
  input  logic [TASK_W-1:0] dst_i [N],
  output logic [NUM_TASKS-1:0] ev_o
);
  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (busy_i[i] && dst_i[i] == TASK_W'(t)) hit = 1'b1;
      end
    end
    assign ev_o[t] = hit;
  end
endmodule

// File: rtl/msg_event_regfile.sv
module msg_event_regfile
  import msg_evrf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int TASK_W    = 3,
  parameter int MSG_W     = 8,
  localparam int IDX_W     = idx_width(NUM_SLOTS),
  localparam int NUM_TASKS = 1 << TASK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 post_i,
  input  logic [TASK_W-1:0]    post_src_i,
  input  logic [TASK_W-1:0]    post_dst_i,
  input  logic [MSG_W-1:0]     post_msg_i,
  output logic                 post_ok_o,
  output logic                 post_rej_o,
  input  logic                 take_i,
  input  logic [IDX_W-1:0]     take_slot_i,
  input  logic [TASK_W-1:0]    take_task_i,
  output logic                 take_ok_o,
  output logic [TASK_W-1:0]    take_src_o,
  output logic [MSG_W-1:0]     take_msg_o,
  output logic [IDX_W-1:0]     free_idx_o,
  output logic                 full_o,
  output logic [NUM_TASKS-1:0] sync_ev_o
);
  logic [NUM_SLOTS-1:0] busy_vec;
  logic [NUM_SLOTS-1:0] wr_vec;
  logic [NUM_SLOTS-1:0] clr_vec;
  logic [TASK_W-1:0]    src_arr [NUM_SLOTS];
  logic [TASK_W-1:0]    dst_arr [NUM_SLOTS];
  logic [MSG_W-1:0]     msg_arr [NUM_SLOTS];

  logic              sel_busy;
  logic [TASK_W-1:0] sel_dst;

  // both commands judged on pre-edge state
  assign post_ok_o  = post_i && !full_o;
  assign post_rej_o = post_i && full_o;

  always_comb begin
    sel_busy   = 1'b0;
    sel_dst    = '0;
    take_src_o = '0;
    take_msg_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (take_slot_i == IDX_W'(i)) begin
        sel_busy   = busy_vec[i];
        sel_dst    = dst_arr[i];
        take_src_o = src_arr[i];
        take_msg_o = msg_arr[i];
      end
    end
  end

  assign take_ok_o = take_i && sel_busy && (sel_dst == take_task_i);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign wr_vec[i]  = post_ok_o && (free_idx_o == IDX_W'(i));
    assign clr_vec[i] = take_ok_o && (take_slot_i == IDX_W'(i));

    msg_slot #(.TASK_W(TASK_W), .MSG_W(MSG_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_vec[i]),
      .clr_i  (clr_vec[i]),
      .src_i  (post_src_i),
      .dst_i  (post_dst_i),
      .msg_i  (post_msg_i),
      .busy_o (busy_vec[i]),
      .src_o  (src_arr[i]),
      .dst_o  (dst_arr[i]),
      .msg_o  (msg_arr[i])
    );
  end

  msg_free_search #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_search (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy_vec),
    .idx_o  (free_idx_o),
    .full_o (full_o)
  );

  msg_event_map #(.N(NUM_SLOTS), .TASK_W(TASK_W), .NUM_TASKS(NUM_TASKS)) u_evmap (
    .busy_i (busy_vec),
    .dst_i  (dst_arr),
    .ev_o   (sync_ev_o)
  );

  AST_POST_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_ok_o |=> busy_vec[$past(free_idx_o)]); // R4
  AST_SYNC_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_ok_o |=> sync_ev_o[$past(post_dst_i)]); // R6
  AST_TAKE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_ok_o |=> !busy_vec[$past(take_slot_i)]); // R7
  AST_FULL_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && post_i && !take_i) |=> full_o); // R5
  AST_BAD_TAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !take_ok_o && !post_i) |=> $stable(busy_vec)); // R8
endmodule

// File: tb/msg_event_regfile_bench.sv
`timescale 1ns/1ps
module msg_event_regfile_bench;
  localparam int NS = 4;
  localparam int TW = 3;
  localparam int MW = 8;
  localparam int IW = 2;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic post_i = 1'b0, take_i = 1'b0;
  logic [TW-1:0] post_src_i = '0, post_dst_i = '0, take_task_i = '0;
  logic [MW-1:0] post_msg_i = '0;
  logic [IW-1:0] take_slot_i = '0;
  logic post_ok_o, post_rej_o, take_ok_o, full_o;
  logic [TW-1:0] take_src_o;
  logic [MW-1:0] take_msg_o;
  logic [IW-1:0] free_idx_o;
  logic [NT-1:0] sync_ev_o;

  always #2 clk = ~clk;

  msg_event_regfile #(.NUM_SLOTS(NS), .TASK_W(TW), .MSG_W(MW)) u_msg_event_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .post_i(post_i), .post_src_i(post_src_i), .post_dst_i(post_dst_i),
    .post_msg_i(post_msg_i), .post_ok_o(post_ok_o), .post_rej_o(post_rej_o),
    .take_i(take_i), .take_slot_i(take_slot_i), .take_task_i(take_task_i),
    .take_ok_o(take_ok_o), .take_src_o(take_src_o), .take_msg_o(take_msg_o),
    .free_idx_o(free_idx_o), .full_o(full_o), .sync_ev_o(sync_ev_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference table built from the requirements
  logic          m_v   [NS];
  logic [TW-1:0] m_src [NS];
  logic [TW-1:0] m_dst [NS];
  logic [MW-1:0] m_msg [NS];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] m_free();
    for (int i = 0; i < NS; i++) if (!m_v[i]) return IW'(i);
    return '0;
  endfunction

  function automatic logic m_full();
    for (int i = 0; i < NS; i++) if (!m_v[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [NT-1:0] m_sync();
    logic [NT-1:0] s = '0;
    for (int i = 0; i < NS; i++) if (m_v[i]) s[m_dst[i]] = 1'b1;
    return s;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < NS; i++) begin
      m_v[i] = 1'b0; m_src[i] = '0; m_dst[i] = '0; m_msg[i] = '0;
    end
  endtask

  task automatic check_state(string req_free);
    if (!m_full()) check({req_free, " free_idx"}, 32'(free_idx_o), 32'(m_free()));
    check("R3 full", 32'(full_o), 32'(m_full()));
    check("R6 sync", 32'(sync_ev_o), 32'(m_sync()));
  endtask

  // post src dst msg | take slot task | exp_post_ok exp_take_ok
  localparam int VW = 23;
  localparam int NV = 13;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 3'd1, 3'd2, 8'hA1, 1'b0, 2'd0, 3'd0, 1'b1, 1'b0},
    {1'b1, 3'd3, 3'd5, 8'hB2, 1'b0, 2'd0, 3'd0, 1'b1, 1'b0},
    {1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd3, 1'b0, 1'b0}, // R8 wrong task
    {1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 2'd3, 3'd0, 1'b0, 1'b0}, // R8 empty slot
    {1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd2, 1'b0, 1'b1}, // R7
    {1'b1, 3'd4, 3'd2, 8'hC3, 1'b0, 2'd0, 3'd0, 1'b1, 1'b0},
    {1'b1, 3'd0, 3'd7, 8'hD4, 1'b0, 2'd0, 3'd0, 1'b1, 1'b0},
    {1'b1, 3'd6, 3'd2, 8'hE5, 1'b0, 2'd0, 3'd0, 1'b1, 1'b0}, // fills table
    {1'b1, 3'd1, 3'd1, 8'hF6, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0}, // R5
    {1'b1, 3'd2, 3'd3, 8'h77, 1'b1, 2'd1, 3'd5, 1'b0, 1'b1}, // R9 full + take
    {1'b1, 3'd5, 3'd6, 8'h88, 1'b1, 2'd2, 3'd7, 1'b1, 1'b1}, // R9 post + take
    {1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 2'd0, 3'd2, 1'b0, 1'b1}, // R6 task 2 still pending
    {1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 2'd3, 3'd2, 1'b0, 1'b1}  // R6 task 2 drops
  };

  task automatic step(logic [VW-1:0] v);
    logic p, t, epok, etok, both, mpok, mtok;
    logic [TW-1:0] s, d, tk;
    logic [MW-1:0] m;
    logic [IW-1:0] sl, fi;
    {p, s, d, m, t, sl, tk, epok, etok} = v;
    both = p && t;
    @(negedge clk);
    post_i = p; post_src_i = s; post_dst_i = d; post_msg_i = m;
    take_i = t; take_slot_i = sl; take_task_i = tk;
    #1;
    mpok = p && !m_full();
    mtok = t && m_v[sl] && (m_dst[sl] == tk);
    check(both ? "R9 post_ok" : (p && !epok) ? "R5 post_ok" : "R4 post_ok", 32'(post_ok_o), 32'(epok));
    check("R5 post_rej", 32'(post_rej_o), 32'(p && !epok));
    check(etok ? "R7 take_ok" : "R8 take_ok", 32'(take_ok_o), 32'(etok));
    check("R4 table vs model post", 32'(epok), 32'(mpok));
    check("R7 table vs model take", 32'(etok), 32'(mtok));
    if (etok) begin
      check("R7 take_msg", 32'(take_msg_o), 32'(m_msg[sl]));
      check("R7 take_src", 32'(take_src_o), 32'(m_src[sl]));
    end
    fi = m_free();
    @(posedge clk);
    if (mpok) begin
      m_v[fi] = 1'b1; m_src[fi] = s; m_dst[fi] = d; m_msg[fi] = m;
    end
    if (mtok) m_v[sl] = 1'b0;
    @(negedge clk);
    post_i = 1'b0; take_i = 1'b0;
    #1;
    check_state(both ? "R9" : "R2");
  endtask

  initial begin
    m_clear();
    repeat (3) @(posedge clk);
    #1;
    check("R1 full in reset", 32'(full_o), 32'd0);
    check("R1 free in reset", 32'(free_idx_o), 32'd0);
    check("R1 sync in reset", 32'(sync_ev_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check_state("R1");

    for (int k = 0; k < NV; k++) step(VEC[k]);

    // refill, then reset mid-run
    step({1'b1, 3'd2, 3'd4, 8'h5A, 1'b0, 2'd0, 3'd0, 1'b1, 1'b0});
    @(negedge clk);
    rst_ni = 1'b0;
    m_clear();
    #1;
    check("R1 async reset sync", 32'(sync_ev_o), 32'd0);
    check("R1 async reset free", 32'(free_idx_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check_state("R1");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule